// File: doc/BRIEF.md
# Line Readout Sequencer

This block steps a line-scanned image sensor through one row and turns the returned samples into a clean pixel stream. A start request sends a one-cycle start-of-row pulse. The block then raises a column-advance enable and an ADC-sample enable together, one sample per clock. It watches the end-of-scan flag that the sensor returns.

The sensor puts out its words in a fixed order: a throwaway word, a dark reference word, a parameterised number of dummy words, the active pixels, and then dark reference words once the row has ended. The ADC word always trails the selected pixel by one sample. The block keeps this lag in its sample counter, so each word gets the right tag. Only active pixels leave as valid data, marked with start-of-line and end-of-line.

The dark reference at the head of the row is latched as the line's dark level. The first dark word after end-of-scan replaces it. When the row is cut short, no trailing dark word exists, so the leading value stays. This happens when the block resets the column register early, either because the pixel count ran out or because of an abort.

Top module: `rowscan_seq`

## Requirements
- R1: After reset, `start` in the idle state gives `row_sync` high for exactly one cycle. `start` raised while a line is in progress is ignored: no second `row_sync` and no extra line follow.
- R2: `col_clk_en` and `adc_clk_en` are high together from the cycle after `row_sync` until the line ends, and low in idle.
- R3: Sample index 2 of the line is tagged dark (tag code 1) and loaded into `dark_level`. Samples are counted from 0 at the first enabled cycle, and index 2 carries the word of the pixel selected at index 1.
- R4: The next DUMMY_PIX samples are tagged dummy (tag code 2) and are not valid.
- R5: Active pixel k is the word sampled at index 3+DUMMY_PIX+k. It appears one cycle later with `pix_valid` high, tag code 3 and the sampled word on `pix_data`. Tag code 0 marks samples carrying no meaning.
- R6: `pix_sol` marks the first active pixel of a line, and `pix_eol` marks the last active pixel that is output.
- R7: When `eos_in` is high at sample index 2+DUMMY_PIX+ACTIVE_PIX, the line ends normally. The next sample is tagged dark and overwrites `dark_level`, and the block returns to idle.
- R8: If `eos_in` arrives earlier during active pixels, the current pixel is the last one (with `pix_eol`), `line_err` is set, and the trailing dark word is still captured.
- R9: If ACTIVE_PIX pixels pass without `eos_in`, the last one carries `pix_eol`, `line_err` is set, and `col_rst` pulses for one cycle. `dark_level` keeps the leading value.
- R10: `abort` during dark, dummy or active samples suppresses the current and all later samples of the line. It pulses `col_rst` for one cycle, gives no `pix_eol`, keeps the leading `dark_level`, and returns to idle.
- R11: `line_err` is sticky: once set it stays high until reset.
- R12: During and right after reset, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to read one row |
| abort | input | 1 | Cut the current row short |
| eos_in | input | 1 | End-of-scan flag from the sensor |
| adc_data | input | DW | Digitised sample, one pixel behind the selection |
| row_sync | output | 1 | Start-of-row pulse to the sensor |
| col_clk_en | output | 1 | Column shift clock enable |
| adc_clk_en | output | 1 | ADC sample clock enable |
| col_rst | output | 1 | Column register reset pulse |
| pix_valid | output | 1 | Active pixel on `pix_data` |
| pix_data | output | DW | Sample word, one cycle after capture |
| pix_sol | output | 1 | First active pixel of the line |
| pix_eol | output | 1 | Last active pixel of the line |
| pix_tag | output | 2 | 0 none, 1 dark, 2 dummy, 3 active |
| dark_level | output | DW | Dark reference of the latest line |
| line_err | output | 1 | Sticky row length mismatch |

## Verification
The bench builds the block with ACTIVE_PIX=8, DUMMY_PIX=2 and DW=10. This keeps each row to about a dozen samples, so both end conditions fit into short runs: a scan flag that arrives early and a count that runs out. Abort lands in both the dummy and the active phase. Two dummies make the dummy tagging visible while keeping the dark, dummy and active boundaries a few cycles apart.

// File: rtl/rowscan_seq.sv
`timescale 1ns/1ps
module rowscan_seq #(
  parameter int DW         = 10,
  parameter int ACTIVE_PIX = 1280,
  parameter int DUMMY_PIX  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          eos_in,
  input  logic [DW-1:0] adc_data,
  output logic          row_sync,
  output logic          col_clk_en,
  output logic          adc_clk_en,
  output logic          col_rst,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  output logic          pix_sol,
  output logic          pix_eol,
  output logic [1:0]    pix_tag,
  output logic [DW-1:0] dark_level,
  output logic          line_err
);
  localparam int LEAD_AT   = 2;
  localparam int ACT_FIRST = LEAD_AT + DUMMY_PIX + 1;
  localparam int ACT_LAST  = ACT_FIRST + ACTIVE_PIX - 1;
  localparam int CW        = $clog2(ACT_LAST + 2);

  typedef enum logic [2:0] {IDLE, SYNC, DARK, DUMMY, ACTIVE, TRAIL} st_t;
  st_t st, st_nx;
  logic [CW-1:0] cnt;

  wire run      = st inside {DARK, DUMMY, ACTIVE, TRAIL};
  wire cut      = abort && (st inside {DARK, DUMMY, ACTIVE});
  wire lead_hit = st == DARK && cnt == CW'(LEAD_AT) && !cut;
  wire act      = st == ACTIVE && !abort;
  wire last     = cnt == CW'(ACT_LAST);
  wire end_eos  = act && eos_in;
  wire end_cnt  = act && !eos_in && last;
  wire dark_smp = lead_hit || st == TRAIL;
  wire bad      = ((st inside {DARK, DUMMY}) && eos_in && !abort)
                  || (end_eos && !last) || end_cnt;

  assign row_sync   = st == SYNC;
  assign col_clk_en = run;
  assign adc_clk_en = run;

  always_comb begin
    st_nx = st;
    unique case (st)
      IDLE:   if (start) st_nx = SYNC;
      SYNC:   st_nx = DARK;
      DARK:   if (cut) st_nx = IDLE;
              else if (eos_in) st_nx = TRAIL;
              else if (lead_hit) st_nx = (DUMMY_PIX > 0) ? DUMMY : ACTIVE;
      DUMMY:  if (cut) st_nx = IDLE;
              else if (eos_in) st_nx = TRAIL;
              else if (cnt == CW'(ACT_FIRST - 1)) st_nx = ACTIVE;
      ACTIVE: if (cut) st_nx = IDLE;
              else if (eos_in) st_nx = TRAIL;
              else if (last) st_nx = IDLE;
      TRAIL:  st_nx = IDLE;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      col_rst    <= 1'b0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_sol    <= 1'b0;
      pix_eol    <= 1'b0;
      pix_tag    <= 2'd0;
      dark_level <= '0;
      line_err   <= 1'b0;
    end else begin
      st        <= st_nx;
      cnt       <= run ? cnt + 1'b1 : '0;
      col_rst   <= cut || end_cnt;
      pix_valid <= act;
      pix_data  <= run ? adc_data : '0;
      pix_sol   <= act && cnt == CW'(ACT_FIRST);
      pix_eol   <= end_eos || end_cnt;
      pix_tag   <= act ? 2'd3 : (st == DUMMY && !cut) ? 2'd2 : dark_smp ? 2'd1 : 2'd0;
      if (dark_smp) dark_level <= adc_data;
      if (bad) line_err <= 1'b1;
    end
  end
endmodule

module rowscan_seq_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_sync,
  input logic          col_clk_en,
  input logic          adc_clk_en,
  input logic          col_rst,
  input logic          pix_valid,
  input logic [DW-1:0] pix_data,
  input logic          pix_sol,
  input logic          pix_eol,
  input logic [1:0]    pix_tag,
  input logic [DW-1:0] dark_level,
  input logic          line_err
);
  // R1
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_sync |=> !row_sync);
  // R2
  sync_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_sync |=> (col_clk_en && adc_clk_en));
  // R2
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_sync |-> !col_clk_en);
  // R3
  dark_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tag == 2'd1) |-> (dark_level == pix_data));
  // R5
  valid_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid == (pix_tag == 2'd3));
  // R6
  sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_valid);
  // R6
  eol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid);
  // R10
  colrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_rst |=> !col_rst);
  // R10
  colrst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_rst |-> !col_clk_en);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> line_err);
endmodule

bind rowscan_seq rowscan_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/rowscan_seq_tb.sv
`timescale 1ns/1ps
module rowscan_seq_tb;
  localparam int DW = 10, N = 8, D = 2;
  localparam int ACT_FIRST = 3 + D;

  logic clk = 0, rst_n = 0, start = 0, abort = 0, eos_in = 0;
  logic [DW-1:0] adc_data = '0;
  logic row_sync, col_clk_en, adc_clk_en, col_rst, pix_valid, pix_sol, pix_eol, line_err;
  logic [DW-1:0] pix_data, dark_level;
  logic [1:0] pix_tag;

  int checks = 0, fails = 0;
  bit err_exp = 0;
  logic [DW-1:0] lead_v, trail_v, base_v;

  always #5 clk = ~clk;

  rowscan_seq #(.DW(DW), .ACTIVE_PIX(N), .DUMMY_PIX(D)) u_dut (.*);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] act_word(input int j);
    return DW'(int'(base_v) + j * 29 + 7);
  endfunction

  function automatic logic [DW-1:0] word_of(input int slot, input int slen);
    if (slot <= 0) return 10'h155;
    if (slot == 1) return lead_v;
    if (slot <= 1 + D) return DW'(10'h2A0 + slot);
    if (slot <= 1 + D + slen) return act_word(slot - 2 - D);
    return trail_v;
  endfunction

  task automatic run_line(input int slen, input int abort_s, input int restart_s);
    int s = 0, nval = 0, ndark = 0, ndum = 0, nsync = 0, nrst = 0, guard = 0;
    int exp_n;
    bit saw_run = 0, done = 0, exp_trail, lerr, lock_ok = 1;
    logic [DW-1:0] exp_dark;
    lead_v  = DW'($urandom);
    trail_v = lead_v ^ 10'h2C3;
    base_v  = DW'($urandom);
    if (abort_s >= 0) begin
      exp_n = (abort_s > ACT_FIRST) ? abort_s - ACT_FIRST : 0;
      exp_trail = 0; lerr = 0;
    end else begin
      exp_n = (slen < N) ? slen : N;
      exp_trail = (slen <= N); lerr = (slen != N);
    end
    exp_dark = exp_trail ? trail_v : lead_v;
    if (lerr) err_exp = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(row_sync && !col_clk_en, "R1 one sync pulse then idle enables", int'(row_sync), 1);
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
      if (col_clk_en != adc_clk_en) lock_ok = 0;
      if (row_sync) nsync++;
      if (col_rst) nrst++;
      if (pix_tag == 2'd1) ndark++;
      if (pix_tag == 2'd2) ndum++;
      if (pix_valid) begin
        chk(pix_data == act_word(nval), "R5 active pixel word", int'(pix_data), int'(act_word(nval)));
        chk(pix_sol == (nval == 0), "R6 start-of-line marker", int'(pix_sol), int'(nval == 0));
        chk(pix_eol == (abort_s < 0 && nval == exp_n - 1), "R6 end-of-line marker",
            int'(pix_eol), int'(abort_s < 0 && nval == exp_n - 1));
        nval++;
      end else if (pix_sol || pix_eol) begin
        chk(0, "R6 marker without valid", 1, 0);
      end
      if (col_clk_en) begin
        saw_run = 1;
        adc_data = word_of(s - 1, slen);
        eos_in = (s == 2 + D + slen);
        abort = (s == abort_s);
        start = (s == restart_s);
        s++;
      end else begin
        adc_data = '0; eos_in = 0; abort = 0; start = 0;
        if (saw_run) done = 1;
      end
    end
    chk(lock_ok, "R2 enables in lockstep", int'(lock_ok), 1);
    chk(nsync == 0, "R1 no further sync during line", nsync, 0);
    chk(nval == exp_n, "R5 R10 active pixel count", nval, exp_n);
    chk(dark_level == exp_dark, "R3 R7 R9 R10 dark level", int'(dark_level), int'(exp_dark));
    chk(line_err == err_exp, "R8 R9 R11 error flag", int'(line_err), int'(err_exp));
    chk(nrst == ((abort_s >= 0 || slen > N) ? 1 : 0), "R9 R10 column reset pulse",
        nrst, (abort_s >= 0 || slen > N) ? 1 : 0);
    if (abort_s < 0) begin
      chk(ndark == 1 + int'(exp_trail), "R3 R7 dark tag count", ndark, 1 + int'(exp_trail));
      chk(ndum == D, "R4 dummy tag count", ndum, D);
    end else begin
      chk(ndark == 1, "R10 only leading dark tagged", ndark, 1);
    end
    repeat (3) begin
      @(negedge clk);
      chk(!row_sync && !col_clk_en, "R1 R7 idle after line", int'(row_sync | col_clk_en), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!row_sync && !col_clk_en && !adc_clk_en && !col_rst && !pix_valid && pix_tag == 0
        && dark_level == 0 && !line_err && pix_data == 0, "R12 reset state", 1, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!row_sync && !col_clk_en && !line_err, "R12 idle after reset", int'(col_clk_en), 0);
    run_line(N, -1, -1);
    for (int i = 0; i < 5; i++) run_line(N, -1, 1 + int'($urandom % 10));
    run_line(N, 7, -1);
    run_line(N, 3, -1);
    run_line(3, -1, -1);
    run_line(N, -1, -1);
    run_line(1, -1, -1);
    run_line(N + 3, -1, -1);
    run_line(N, 6 + int'($urandom % 6), -1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!line_err, "R11 error clears only on reset", int'(line_err), 0);
    err_exp = 0;
    run_line(N, -1, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule